// File: doc/BRIEF.md
# Triangle Spread-Spectrum Offset Generator

This block produces the slowly varying offset that a fractional-N feedback divider adds to its nominal fractional word to spread the spectrum of the synthesized clock. The offset follows a symmetric triangle. Time is measured in advance ticks, not in system clocks. Each tick stands for one cycle of the synthesized output clock. On every tick the offset moves by a programmable step. The number of ticks in one rising or falling leg is programmable; a leg is half of a full modulation cycle.

In centre mode the triangle swings both above and below the nominal word, within plus and minus a programmed peak deviation. In down mode it swings only below the nominal word, between minus the peak deviation and zero. When the block is enabled, the offset starts at zero and first descends to the lowest point. From there it alternates between rising and falling legs. Step, leg length and mode changes are picked up only at a lowest point, so the profile never jumps. The peak deviation is picked up only when the block is enabled. The offset saturates at the limits instead of wrapping.

The controller is a state machine with four states:
- `ST_IDLE`: spread off, offset held at zero.
- `ST_ENTRY`: first descent from the nominal value.
- `ST_RISE`: rising leg.
- `ST_FALL`: falling leg.

Its transitions are:
- enable: `ST_IDLE` to `ST_ENTRY`.
- entry done: `ST_ENTRY` to `ST_RISE`, at a lowest point.
- top reached: `ST_RISE` to `ST_FALL`.
- bottom reached: `ST_FALL` to `ST_RISE`, at a lowest point.
- disable: any state to `ST_IDLE`.

Top module: `ss_tri_mod`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `frac_out` equals `frac_nom` and `ramp_up` is 0.
- R2: At each clock edge where `spread_en` is 0, the offset returns to zero, the period count returns to zero and ticks are ignored. From the next cycle on, `frac_out` equals `frac_nom` and `ramp_up` is 0. A later enable restarts the profile from the nominal value.
- R3: At an edge where `tick` is 0, the offset and `ramp_up` keep their values.
- R4: In centre mode (`down_mode`=0), the entry leg lasts floor(P/2) ticks and each tick lowers the offset by S. After it come rising and falling legs of P ticks each, moving by +S and -S per tick. P and S are the latched leg length and step.
- R5: In down mode (`down_mode`=1), the entry leg lasts P ticks. The offset stays between -A and 0, where A is `peak_dev`, so `frac_out` never exceeds `frac_nom` modulo the word width.
- R6: A step that would leave the range clamps the offset at the limit. The range is [-A, +A] in centre mode and [-A, 0] in down mode. The leg still lasts its full tick count.
- R7: A leg length of zero acts as one tick. So does a centre-mode entry leg whose halved length is zero.
- R8: `frac_out` equals `frac_nom` plus the sign-extended offset, modulo 2^FRAC_W.
- R9: Step, leg length and mode are sampled at enable and again at the end of each entry or falling leg. Changes at other times have no effect until then. `peak_dev` is sampled only at enable.
- R10: `ramp_up` is 1 exactly while a rising leg is in progress. It changes only at an edge carrying a tick or at a disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Advance enable, one pulse per output-clock cycle |
| spread_en | input | 1 | Enables modulation; 0 holds the output at nominal |
| down_mode | input | 1 | 0 = centre spread, 1 = down spread |
| step_size | input | STEP_W | Offset change per tick |
| half_period | input | PER_W | Ticks per rising or falling leg |
| peak_dev | input | AMP_W | Peak offset magnitude |
| frac_nom | input | FRAC_W | Nominal fractional word |
| frac_out | output | FRAC_W | Modulated fractional word |
| ramp_up | output | 1 | 1 during a rising leg |

## Verification
The bench builds the block with a 16-bit fractional word, a 12-bit offset, an 8-bit step, a 6-bit leg length and a 10-bit peak deviation. Small limits let a large step hit saturation within a few ticks. Nominal words close to zero and to all-ones make the modulo wrap of the output sum reachable. The narrow leg counter makes zero and one-tick legs cheap to reach. A behavioural model of the triangle, written from the requirements, follows every cycle of each run. Sparse tick patterns show that the profile is timed by ticks and not by clock cycles.

// File: rtl/ss_tri_pkg.sv
package ss_tri_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ENTRY = 2'd1,
        ST_RISE  = 2'd2,
        ST_FALL  = 2'd3
    } ss_state_e;

endpackage

// File: rtl/ss_cfg_shadow.sv
module ss_cfg_shadow #(
    parameter int STEP_W = 12,
    parameter int PER_W  = 16,
    parameter int AMP_W  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_all,
    input  logic              ld_shape,
    input  logic [STEP_W-1:0] step_in,
    input  logic [PER_W-1:0]  per_in,
    input  logic [AMP_W-1:0]  amp_in,
    input  logic              down_in,
    output logic [STEP_W-1:0] step_q,
    output logic [PER_W-1:0]  per_q,
    output logic [AMP_W-1:0]  amp_q,
    output logic              down_q
);

    // Shape settings reload at enable and at every lowest point
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            per_q  <= '0;
            down_q <= 1'b0;
        end else if (ld_all || ld_shape) begin
            step_q <= step_in;
            per_q  <= per_in;
            down_q <= down_in;
        end
    end

    // Peak deviation reloads only at enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            amp_q <= '0;
        end else if (ld_all) begin
            amp_q <= amp_in;
        end
    end

endmodule

// File: rtl/ss_leg_counter.sv
module ss_leg_counter #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [PER_W-1:0] len,
    output logic             last
);

    localparam int CNT_X = PER_W + 1;

    logic [PER_W-1:0] cnt_q;
    logic [CNT_X-1:0] cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + CNT_X'(1);
        // a length of zero ends the leg after one tick
        last    = adv && (cnt_inc >= {1'b0, len});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= last ? '0 : cnt_inc[PER_W-1:0];
        end
    end

endmodule

// File: rtl/ss_sat_accum.sv
module ss_sat_accum #(
    parameter int OFS_W  = 20,
    parameter int STEP_W = 12,
    parameter int AMP_W  = 18
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    adv,
    input  logic                    up,
    input  logic [STEP_W-1:0]       step,
    input  logic [AMP_W-1:0]        amp,
    input  logic                    down,
    output logic signed [OFS_W-1:0] acc_q
);

    localparam int EXT_W = OFS_W + 2;

    logic signed [EXT_W-1:0] acc_x;
    logic signed [EXT_W-1:0] step_x;
    logic signed [EXT_W-1:0] amp_x;
    logic signed [EXT_W-1:0] lo_x;
    logic signed [EXT_W-1:0] hi_x;
    logic signed [EXT_W-1:0] sum_x;
    logic signed [EXT_W-1:0] nxt_x;

    always_comb begin
        acc_x  = EXT_W'(acc_q);
        step_x = $signed({{(EXT_W-STEP_W){1'b0}}, step});
        amp_x  = $signed({{(EXT_W-AMP_W){1'b0}}, amp});
        lo_x   = -amp_x;
        hi_x   = down ? '0 : amp_x;
        sum_x  = up ? (acc_x + step_x) : (acc_x - step_x);
        if (sum_x > hi_x) begin
            nxt_x = hi_x;
        end else if (sum_x < lo_x) begin
            nxt_x = lo_x;
        end else begin
            nxt_x = sum_x;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (adv) begin
            acc_q <= nxt_x[OFS_W-1:0];
        end
    end

endmodule

// File: rtl/ss_tri_mod.sv
module ss_tri_mod
    import ss_tri_pkg::*;
#(
    parameter int FRAC_W = 24,
    parameter int OFS_W  = 20,
    parameter int STEP_W = 12,
    parameter int PER_W  = 16,
    parameter int AMP_W  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              spread_en,
    input  logic              down_mode,
    input  logic [STEP_W-1:0] step_size,
    input  logic [PER_W-1:0]  half_period,
    input  logic [AMP_W-1:0]  peak_dev,
    input  logic [FRAC_W-1:0] frac_nom,
    output logic [FRAC_W-1:0] frac_out,
    output logic              ramp_up
);

    ss_state_e state_q;
    ss_state_e state_d;

    logic [STEP_W-1:0]       step_q;
    logic [PER_W-1:0]        per_q;
    logic [AMP_W-1:0]        amp_q;
    logic                    down_q;
    logic signed [OFS_W-1:0] acc_q;
    logic [FRAC_W-1:0]       ofs_ext;

    logic             adv;
    logic             leg_last;
    logic [PER_W-1:0] leg_len;
    logic             ld_all;
    logic             ld_shape;
    logic             cnt_clr;

    // Control decode
    always_comb begin
        adv      = spread_en && tick && (state_q != ST_IDLE);
        ld_all   = spread_en && (state_q == ST_IDLE);
        ld_shape = spread_en && leg_last &&
                   ((state_q == ST_ENTRY) || (state_q == ST_FALL));
        cnt_clr  = !spread_en || (state_q == ST_IDLE);
        unique case (state_q)
            ST_ENTRY: leg_len = down_q ? per_q : (per_q >> 1);
            default:  leg_len = per_q;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!spread_en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_ENTRY;
                ST_ENTRY: if (leg_last) state_d = ST_RISE;
                ST_RISE:  if (leg_last) state_d = ST_FALL;
                ST_FALL:  if (leg_last) state_d = ST_RISE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    ss_cfg_shadow #(
        .STEP_W (STEP_W),
        .PER_W  (PER_W),
        .AMP_W  (AMP_W)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_all   (ld_all),
        .ld_shape (ld_shape),
        .step_in  (step_size),
        .per_in   (half_period),
        .amp_in   (peak_dev),
        .down_in  (down_mode),
        .step_q   (step_q),
        .per_q    (per_q),
        .amp_q    (amp_q),
        .down_q   (down_q)
    );

    ss_leg_counter #(
        .PER_W (PER_W)
    ) u_leg (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .adv   (adv),
        .len   (leg_len),
        .last  (leg_last)
    );

    ss_sat_accum #(
        .OFS_W  (OFS_W),
        .STEP_W (STEP_W),
        .AMP_W  (AMP_W)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!spread_en),
        .adv   (adv),
        .up    (state_q == ST_RISE),
        .step  (step_q),
        .amp   (amp_q),
        .down  (down_q),
        .acc_q (acc_q)
    );

    // Offset widening picks a variant from the width relation
    generate
        if (FRAC_W > OFS_W) begin : g_sext
            assign ofs_ext = {{(FRAC_W-OFS_W){acc_q[OFS_W-1]}}, acc_q};
        end else begin : g_trunc
            assign ofs_ext = acc_q[FRAC_W-1:0];
        end
    endgenerate

    // Outputs
    always_comb begin
        ramp_up  = (state_q == ST_RISE);
        frac_out = frac_nom + ofs_ext;
    end

endmodule

// File: rtl/ss_tri_mod_chk.sv
module ss_tri_mod_chk #(
    parameter int FRAC_W = 24,
    parameter int OFS_W  = 20,
    parameter int STEP_W = 12,
    parameter int AMP_W  = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              spread_en,
    input logic [FRAC_W-1:0] frac_nom,
    input logic [FRAC_W-1:0] frac_out,
    input logic              ramp_up,
    input logic [OFS_W-1:0]  acc_q,
    input logic [AMP_W-1:0]  amp_q,
    input logic [STEP_W-1:0] step_q,
    input logic              down_q
);

    localparam int EXT_W = OFS_W + 2;

    logic signed [EXT_W-1:0] acc_x;
    logic signed [EXT_W-1:0] amp_x;
    logic signed [EXT_W-1:0] top_x;

    always_comb begin
        acc_x = EXT_W'($signed(acc_q));
        amp_x = $signed({{(EXT_W-AMP_W){1'b0}}, amp_q});
        top_x = down_q ? '0 : amp_x;
    end

    AST_IDLE_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
        !spread_en |=> ((frac_out == frac_nom) && !ramp_up)); // R2

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (spread_en && !tick) |=> ($stable(acc_q) && $stable(ramp_up))); // R3

    AST_RISE_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (spread_en && tick && ramp_up) |=> ($signed(acc_q) >= $signed($past(acc_q)))); // R4

    AST_FALL_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (spread_en && tick && !ramp_up) |=> ($signed(acc_q) <= $signed($past(acc_q)))); // R4

    AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_x >= -amp_x) && (acc_x <= top_x)); // R6

    AST_SHAPE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_up && $past(ramp_up)) |-> ($stable(step_q) && $stable(down_q))); // R9

    AST_FLAG_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ramp_up) |-> ($past(tick) || !$past(spread_en))); // R10

endmodule

bind ss_tri_mod ss_tri_mod_chk #(
    .FRAC_W (FRAC_W),
    .OFS_W  (OFS_W),
    .STEP_W (STEP_W),
    .AMP_W  (AMP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .spread_en (spread_en),
    .frac_nom  (frac_nom),
    .frac_out  (frac_out),
    .ramp_up   (ramp_up),
    .acc_q     (acc_q),
    .amp_q     (amp_q),
    .step_q    (step_q),
    .down_q    (down_q)
);

// File: tb/ss_tri_mod_bench.sv
`timescale 1ns/1ps
module ss_tri_mod_bench;

    localparam int FRAC_W = 16;
    localparam int OFS_W  = 12;
    localparam int STEP_W = 8;
    localparam int PER_W  = 6;
    localparam int AMP_W  = 10;

    typedef struct packed {
        logic [7:0]  step;
        logic [5:0]  per;
        logic [9:0]  amp;
        logic        down;
        logic [15:0] nom;
        logic [3:0]  gap;
        logic [7:0]  ncyc;
        logic [3:0]  rq;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{8'd5,  6'd8,  10'd100, 1'b0, 16'h4000, 4'd1, 8'd60, 4'd4},
        '{8'd3,  6'd6,  10'd50,  1'b1, 16'h2000, 4'd2, 8'd80, 4'd5},
        '{8'd40, 6'd10, 10'd100, 1'b0, 16'h1000, 4'd1, 8'd50, 4'd6},
        '{8'd30, 6'd7,  10'd90,  1'b1, 16'h0800, 4'd1, 8'd50, 4'd6},
        '{8'd7,  6'd5,  10'd200, 1'b0, 16'h0003, 4'd1, 8'd40, 4'd8},
        '{8'd2,  6'd0,  10'd20,  1'b0, 16'hFFFE, 4'd3, 8'd30, 4'd7},
        '{8'd1,  6'd1,  10'd10,  1'b0, 16'h1234, 4'd1, 8'd20, 4'd7}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              spread_en = 1'b0;
    logic              down_mode = 1'b0;
    logic [STEP_W-1:0] step_size = '0;
    logic [PER_W-1:0]  half_period = '0;
    logic [AMP_W-1:0]  peak_dev = '0;
    logic [FRAC_W-1:0] frac_nom = 16'h1111;
    logic [FRAC_W-1:0] frac_out;
    logic              ramp_up;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    int m_st = 0, m_acc = 0, m_cnt = 0;
    int s_step = 0, s_per = 0, s_amp = 0;
    bit s_down = 0;

    always #2 clk = ~clk;

    ss_tri_mod #(
        .FRAC_W (FRAC_W), .OFS_W (OFS_W), .STEP_W (STEP_W),
        .PER_W (PER_W), .AMP_W (AMP_W)
    ) u_ss_tri_mod (
        .clk (clk), .rst_n (rst_n), .tick (tick), .spread_en (spread_en),
        .down_mode (down_mode), .step_size (step_size),
        .half_period (half_period), .peak_dev (peak_dev),
        .frac_nom (frac_nom), .frac_out (frac_out), .ramp_up (ramp_up)
    );

    task automatic model_update();
        int len;
        if (!rst_n || !spread_en) begin
            m_st = 0; m_acc = 0; m_cnt = 0;
            if (!rst_n) begin
                s_step = 0; s_per = 0; s_amp = 0; s_down = 0;
            end
        end else if (m_st == 0) begin
            s_step = int'(step_size); s_per = int'(half_period);
            s_amp = int'(peak_dev); s_down = down_mode;
            m_st = 1; m_cnt = 0;
        end else if (tick) begin
            len = (m_st == 1) ? (s_down ? s_per : s_per / 2) : s_per;
            if (len == 0) len = 1;
            if (m_st == 2) begin
                m_acc = m_acc + s_step;
                if (m_acc > (s_down ? 0 : s_amp)) m_acc = s_down ? 0 : s_amp;
            end else begin
                m_acc = m_acc - s_step;
                if (m_acc < -s_amp) m_acc = -s_amp;
            end
            if (m_cnt + 1 >= len) begin
                m_cnt = 0;
                if (m_st == 2) begin
                    m_st = 3;
                end else begin
                    m_st = 2;
                    s_step = int'(step_size); s_per = int'(half_period);
                    s_down = down_mode;
                end
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    endtask

    task automatic chk16(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s frac_out actual=%h expected=%h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic chkb(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s ramp_up actual=%b expected=%b at %0t", req, got, exp, $time);
        end
    endtask

    // one clock: inputs already set, model follows the edge, sample 1 ns later
    task automatic cyc(input logic t);
        tick = t;
        @(posedge clk);
        model_update();
        #1;
    endtask

    task automatic cmp_model(input string req);
        logic [15:0] e;
        e = frac_nom + 16'(m_acc);
        chk16(req, frac_out, e);
        chkb("R10", ramp_up, (m_st == 2));
    endtask

    function automatic string tag_of(input logic [3:0] n);
        case (n)
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            default: return "R8";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R4 watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] hold_v;
        logic        hold_r;
        // R1: reset with enable and ticks active
        rst_n = 0; spread_en = 1; step_size = 8'd9; half_period = 6'd4; peak_dev = 10'd50;
        for (int k = 0; k < 3; k++) begin
            cyc(1);
            chk16("R1", frac_out, frac_nom);
            chkb("R1", ramp_up, 1'b0);
        end
        spread_en = 0;
        rst_n = 1;
        cyc(1);
        chk16("R1", frac_out, frac_nom);
        chkb("R1", ramp_up, 1'b0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            spread_en = 0;
            cyc(0);
            step_size = VECS[i].step; half_period = VECS[i].per;
            peak_dev = VECS[i].amp; down_mode = VECS[i].down; frac_nom = VECS[i].nom;
            spread_en = 1;
            for (int c = 0; c < int'(VECS[i].ncyc); c++) begin
                cyc((c % int'(VECS[i].gap)) == 0);
                cmp_model(tag_of(VECS[i].rq));
            end
        end

        // R2: disable with ticks, nominal changing
        for (int k = 0; k < 5; k++) begin
            spread_en = 0;
            frac_nom = 16'h3000 + 16'(k);
            cyc(1);
            chk16("R2", frac_out, 16'h3000 + 16'(k));
            chkb("R2", ramp_up, 1'b0);
        end
        // R2: re-enable restarts from nominal
        step_size = 8'd4; half_period = 6'd4; peak_dev = 10'd200; down_mode = 0;
        spread_en = 1;
        cyc(1);
        chk16("R2", frac_out, 16'h3004);
        for (int k = 0; k < 7; k++) begin
            cyc(1);
            cmp_model("R2");
        end

        // R3: no ticks means hold
        hold_v = frac_out; hold_r = ramp_up;
        for (int k = 0; k < 6; k++) begin
            cyc(0);
            chk16("R3", frac_out, hold_v);
            chkb("R3", ramp_up, hold_r);
        end

        // R9: restart, reach rising leg, change settings mid-rise
        spread_en = 0; cyc(0);
        frac_nom = 16'h1000; step_size = 8'd4; half_period = 6'd4;
        peak_dev = 10'd200; down_mode = 0; spread_en = 1;
        cyc(0);
        cyc(1); cyc(1);
        chk16("R9", frac_out, 16'h1000 - 16'd8);
        chkb("R9", ramp_up, 1'b1);
        step_size = 8'd9; half_period = 6'd2; down_mode = 1; peak_dev = 10'd5;
        hold_v = frac_out;
        cyc(1);
        chk16("R9", frac_out, hold_v + 16'd4);
        for (int k = 0; k < 20; k++) begin
            cyc(1);
            cmp_model("R9");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule